// File: doc/BRIEF.md
# Pipelined ADC Digit Combiner

This block turns the raw codes of a pipelined analog-to-digital converter into one corrected binary word per channel. Two coarse stages, each resolving one and a half bits, sit ahead of a fine binary converter. Each coarse stage reports a two-bit thermometer code that stands for a signed digit of -1, 0 or +1. The stages resolve one sample in successive clocks, so the second coarse code arrives one clock after the first and the fine code one clock after that.

The block delays the earlier codes until they meet the later codes of the same sample, and it carries the channel tag alongside. It then adds the three parts with overlapping weights. Because the coarse digits overlap the fine range, a comparator offset in a coarse stage moves the residue rather than the result, and the sum still lands on the correct code. A new sample may be presented every clock, and one corrected word leaves per clock after a fixed latency.

Top module: `pipe_adc_combiner`

## Requirements
- R1: A synchronous active-high reset clears every alignment register; after each clock edge with reset high, out_vld, out_word, out_chan and out_err are all zero, and samples in flight at that edge are dropped.
- R2: A coarse code is read as a count of its set bits: 00 counts 0, 01 counts 1, 11 counts 2 (the signed digit plus one).
- R3: out_word equals count(first stage) * 2^FINE_W + count(second stage) * 2^(FINE_W-1) + fine code; with FINE_W = 8 the range is 0 to 1023 and needs no saturation.
- R4: With default lags, a sample whose in_vld, in_chan and st1_code are taken at clock edge k has its st2_code taken at edge k+1 and its fine_code at edge k+2, and its result is on the outputs right after edge k+2.
- R5: out_chan equals the in_chan given with the same sample's first-stage code.
- R6: The code 10 is illegal; out_err is high for a result whose first- or second-stage code was 10, and the code then counts as 1 (as 01) in the sum; otherwise out_err is low.
- R7: Samples presented on consecutive clocks produce results on consecutive clocks, one per clock.
- R8: A clock with in_vld low produces a clock with out_vld low at the matching output slot.
- R9: When each stage subtracts digit times a quarter of Vref and doubles, with comparator thresholds at plus and minus Vref/8 each shifted by less than Vref/8, the output equals the ideal 10-bit quantization of an input spanning plus and minus Vref/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A new sample starts this clock |
| in_chan | input | CH_W | Channel tag of the new sample |
| st1_code | input | 2 | First coarse stage thermometer code of the new sample |
| st2_code | input | 2 | Second coarse stage code, for the sample started S2_LAG clocks earlier |
| fine_code | input | FINE_W | Fine converter code, for the sample started S2_LAG+FINE_LAG clocks earlier |
| out_vld | output | 1 | Result valid strobe |
| out_chan | output | CH_W | Channel tag of the result |
| out_word | output | FINE_W+2 | Corrected binary result |
| out_err | output | 1 | An illegal coarse code fed this result |

## Verification
Each sample's three codes are driven on three successive clocks, so the stimulus for one sample is spread over the edges k, k+1 and k+2 while the next samples overlap it. The bench keeps all stimulus in per-edge tables and, in the low phase after edge e, compares the outputs with the sample started at edge e-2, dropping it from the expectation if reset was high on any of its three edges. Samples built from a model of the analog stages with random comparator offsets are checked a second time against the ideal quantization of their input voltage.

// File: rtl/pac_pkg.sv
package pac_pkg;

   // Number of set bits of a coarse thermometer code: signed digit plus one.
   // The illegal code 10 also yields 1, the same as 01.
   function automatic logic [1:0] pac_weight(input logic [1:0] code);
      return {1'b0, code[1]} + {1'b0, code[0]};
   endfunction

   localparam int PAC_MAX_LAG = 4;

endpackage

// File: rtl/pac_stage_decode.sv
module pac_stage_decode
   import pac_pkg::*;
(
   input  logic [1:0] code,
   output logic [1:0] weight,
   output logic       illegal
);

   always_comb begin
      weight  = pac_weight(code);
      illegal = code[1] & ~code[0];
   end

endmodule

// File: rtl/pac_delay.sv
module pac_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("pac_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_pipe
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  stg [DEPTH];
      logic [CW-1:0] fill;

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end

      always_ff @(posedge clk) begin
         if (rst) fill <= '0;
         else if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
      end

      assign q = stg[DEPTH-1];

      // R4: the output repeats the input exactly DEPTH clocks later
      a_r4_delay_exact: assert property (@(posedge clk) disable iff (rst)
         (fill == CW'(DEPTH)) |-> (q == $past(d, DEPTH)));
   end

endmodule

// File: rtl/pipe_adc_combiner.sv
module pipe_adc_combiner
   import pac_pkg::*;
#(
   parameter int CH_W     = 6,
   parameter int FINE_W   = 8,
   parameter int S2_LAG   = 1,
   parameter int FINE_LAG = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [1:0]        st1_code,
   input  logic [1:0]        st2_code,
   input  logic [FINE_W-1:0] fine_code,
   output logic              out_vld,
   output logic [CH_W-1:0]   out_chan,
   output logic [FINE_W+1:0] out_word,
   output logic              out_err
);

   localparam int OUT_W  = FINE_W + 2;
   localparam int A_W    = 1 + CH_W + 2 + 1;
   localparam int B_W    = 1 + CH_W + 3 + 1;
   localparam int LAT    = S2_LAG + FINE_LAG + 1;
   localparam int WARM_W = $clog2(LAT + 1);
   localparam int UNIT   = 1 << (FINE_W - 1);

   if (S2_LAG < 0 || S2_LAG > PAC_MAX_LAG ||
       FINE_LAG < 0 || FINE_LAG > PAC_MAX_LAG) begin : g_bad_lag
      $error("pipe_adc_combiner: stage lags must lie in 0..PAC_MAX_LAG");
   end
   if (FINE_W < 2 || CH_W < 1) begin : g_bad_width
      $error("pipe_adc_combiner: FINE_W must be at least 2 and CH_W at least 1");
   end

   // ---------------- coarse code decode ----------------
   logic [1:0] w1, w2;
   logic       e1, e2;

   pac_stage_decode u_dec1 (.code(st1_code), .weight(w1), .illegal(e1));
   pac_stage_decode u_dec2 (.code(st2_code), .weight(w2), .illegal(e2));

   // ---------------- align stage 1 with stage 2 ----------------
   logic [A_W-1:0] a_d, a_q;
   logic              a_vld, a_err;
   logic [CH_W-1:0]   a_chan;
   logic [1:0]        a_w1;

   assign a_d = {in_vld, in_chan, w1, e1};

   pac_delay #(.W(A_W), .DEPTH(S2_LAG)) u_dly_a (
      .clk(clk), .rst(rst), .d(a_d), .q(a_q));

   assign a_vld  = a_q[A_W-1];
   assign a_chan = a_q[A_W-2 -: CH_W];
   assign a_w1   = a_q[2:1];
   assign a_err  = a_q[0];

   // coarse partial sum in units of half the fine span: 2*w1 + w2, at most 6
   logic [2:0] part;
   assign part = {a_w1, 1'b0} + {1'b0, w2};

   // ---------------- align coarse sum with fine code ----------------
   logic [B_W-1:0] b_d, b_q;
   logic              b_vld, b_err;
   logic [CH_W-1:0]   b_chan;
   logic [2:0]        b_part;

   assign b_d = {a_vld, a_chan, part, a_err | e2};

   pac_delay #(.W(B_W), .DEPTH(FINE_LAG)) u_dly_b (
      .clk(clk), .rst(rst), .d(b_d), .q(b_q));

   assign b_vld  = b_q[B_W-1];
   assign b_chan = b_q[B_W-2 -: CH_W];
   assign b_part = b_q[3:1];
   assign b_err  = b_q[0];

   // ---------------- final overlapped addition ----------------
   logic [OUT_W-1:0] sum_word;
   assign sum_word = {b_part, {(FINE_W-1){1'b0}}} + {2'b00, fine_code};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_chan <= '0;
         out_word <= '0;
         out_err  <= 1'b0;
      end else begin
         out_vld  <= b_vld;
         out_chan <= b_chan;
         out_word <= sum_word;
         out_err  <= b_err;
      end
   end

   // ---------------- checks ----------------
   logic [WARM_W-1:0] warm_cnt;
   logic              warm;

   always_ff @(posedge clk) begin
      if (rst) warm_cnt <= '0;
      else if (warm_cnt != WARM_W'(LAT)) warm_cnt <= warm_cnt + 1'b1;
   end
   assign warm = (warm_cnt == WARM_W'(LAT));

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_vld && out_word == '0 && out_chan == '0 && !out_err));

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      warm |-> (out_vld == $past(in_vld, LAT)));

   a_r5_chan_travels: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld) |-> (out_chan == $past(in_chan, LAT)));

   a_r6_illegal_flag: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld) |-> (out_err ==
         (($past(st1_code, LAT) == 2'b10) || ($past(st2_code, FINE_LAG + 1) == 2'b10))));

   a_r3_overlap_sum: assert property (@(posedge clk) disable iff (rst)
      (warm && out_vld) |-> (int'(out_word) ==
         int'(pac_weight($past(st1_code, LAT))) * 2 * UNIT +
         int'(pac_weight($past(st2_code, FINE_LAG + 1))) * UNIT +
         int'($past(fine_code))));

endmodule

// File: tb/sim_pipe_adc_combiner.sv
module sim_pipe_adc_combiner;
   localparam int CH_W = 6;
   localparam int FW   = 8;
   localparam int NE   = 320;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_vld = 1'b0;
   logic [CH_W-1:0] in_chan = '0;
   logic [1:0]    st1_code = '0, st2_code = '0;
   logic [FW-1:0] fine_code = '0;
   logic          out_vld, out_err;
   logic [CH_W-1:0] out_chan;
   logic [FW+1:0] out_word;

   always #5 clk = ~clk;

   pipe_adc_combiner #(.CH_W(CH_W), .FINE_W(FW)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_chan(in_chan),
      .st1_code(st1_code), .st2_code(st2_code), .fine_code(fine_code),
      .out_vld(out_vld), .out_chan(out_chan), .out_word(out_word), .out_err(out_err));

   bit              t_v  [NE];
   bit              t_rs [NE];
   bit              t_an [NE];
   logic [CH_W-1:0] t_ch [NE];
   logic [1:0]      t_s1 [NE];
   logic [1:0]      t_s2 [NE];
   logic [FW-1:0]   t_f  [NE];
   int              t_id [NE];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic int ones2(logic [1:0] c);
      return int'(c[0]) + int'(c[1]);
   endfunction

   function automatic int exp_word(int k);
      return ones2(t_s1[k]) * 256 + ones2(t_s2[k]) * 128 + int'(t_f[k]);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // analog model, Vref = 8192 units, input span -4096..4095
   function automatic logic [1:0] quant(int v, int lo_off, int hi_off);
      if (v < -1024 + lo_off) return 2'b00;
      if (v <  1024 + hi_off) return 2'b01;
      return 2'b11;
   endfunction

   function automatic int dig(logic [1:0] c);
      return ones2(c) - 1;
   endfunction

   task automatic model(int k, int vin, int a1, int b1, int a2, int b2);
      int r1, r2, f;
      t_an[k] = 1;
      t_v[k]  = 1;
      t_s1[k] = quant(vin, a1, b1);
      r1 = 2 * (vin - dig(t_s1[k]) * 2048);
      t_s2[k] = quant(r1, a2, b2);
      r2 = 2 * (r1 - dig(t_s2[k]) * 2048);
      f = (r2 + 4096) >>> 5;
      if (f < 0) f = 0;
      if (f > 255) f = 255;
      t_f[k]  = FW'(f);
      t_id[k] = (vin + 4096) >> 3;
   endtask

   function automatic int offs();
      return int'($urandom_range(0, 1998)) - 999;
   endfunction

   task automatic direct(int k, bit v, logic [1:0] a, logic [1:0] b, int f);
      t_v[k] = v; t_s1[k] = a; t_s2[k] = b; t_f[k] = FW'(f);
   endtask

   initial begin
      void'($urandom(32'd20141218));
      for (int k = 0; k < NE; k++) begin
         t_rs[k] = (k < 4) || (k == 200);
         t_an[k] = 0;
         t_v[k]  = 0;
         t_ch[k] = CH_W'($urandom);
         t_s1[k] = 2'b00; t_s2[k] = 2'b00; t_f[k] = '0; t_id[k] = 0;
         if (k < 4) begin
            t_v[k] = 1;   // held valid during reset: must never emerge (R1)
         end else if (k < 14) begin
            case (k)
               4:  direct(k, 1, 2'b00, 2'b00, 0);     // 0
               5:  direct(k, 1, 2'b11, 2'b11, 255);   // 1023
               6:  direct(k, 1, 2'b01, 2'b01, 0);     // 384
               7:  direct(k, 1, 2'b11, 2'b00, 0);     // 512
               8:  direct(k, 1, 2'b00, 2'b11, 127);   // 383
               9:  direct(k, 0, 2'b11, 2'b11, 255);   // gap (R8)
               10: direct(k, 1, 2'b10, 2'b01, 5);     // illegal first
               11: direct(k, 1, 2'b01, 2'b10, 7);     // illegal second
               12: direct(k, 1, 2'b10, 2'b10, 0);
               default: direct(k, 1, 2'b00, 2'b01, 200);
            endcase
         end else if (k == 14) model(k,  4095,  999,  999,  999,  999);
         else if (k == 15)     model(k, -4096, -999, -999, -999, -999);
         else if (k == 16)     model(k,     0,  999, -999, -999,  999);
         else if (k == 17)     model(k,  1030,  999,  999, -999, -999);
         else begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0) begin
               direct(k, 0, 2'($urandom), 2'($urandom), int'($urandom_range(0, 255)));
            end else if (r <= 6) begin
               model(k, int'($urandom_range(0, 8191)) - 4096, offs(), offs(), offs(), offs());
            end else begin
               direct(k, 1, 2'($urandom), 2'($urandom), int'($urandom_range(0, 255)));
            end
         end
      end

      for (int e = 0; e < NE; e++) begin
         @(negedge clk);
         rst       = t_rs[e];
         in_vld    = t_v[e];
         in_chan   = t_ch[e];
         st1_code  = t_s1[e];
         st2_code  = (e >= 1) ? t_s2[e-1] : 2'b00;
         fine_code = (e >= 2) ? t_f[e-2]  : '0;
         @(posedge clk);
         #2;
         if (t_rs[e]) begin
            check(!out_vld && out_word == '0 && out_chan == '0 && !out_err,
                  "R1 reset clear", int'(out_vld) + int'(out_word), 0);
         end else if (e >= 2) begin
            int  k;
            bit  ev;
            k  = e - 2;
            ev = t_v[k] && !t_rs[k] && !t_rs[k+1];
            check(out_vld == ev, "R4/R7/R8 out_vld slot", int'(out_vld), int'(ev));
            if (ev) begin
               check(int'(out_word) == exp_word(k), "R2/R3 word", int'(out_word), exp_word(k));
               check(out_chan == t_ch[k], "R5 channel", int'(out_chan), int'(t_ch[k]));
               check(out_err == ((t_s1[k] == 2'b10) || (t_s2[k] == 2'b10)), "R6 error flag",
                     int'(out_err), int'((t_s1[k] == 2'b10) || (t_s2[k] == 2'b10)));
               if (t_an[k])
                  check(int'(out_word) == t_id[k], "R9 offset tolerance", int'(out_word), t_id[k]);
            end
         end
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule